// File: doc/BRIEF.md
# Time-Aware Gate Sequencer

This block drives the eight transmit-queue gates of one Ethernet port from a stored schedule. Each schedule is a list of 22-bit commands in an internal fetch RAM. A command pairs a gate-open mask with a duration counted in wire-side clock cycles. An external time base sends a pulse at the start of every schedule cycle, and the sequencer then walks the list again from the top. The result is an 8-bit `gate_mask` that a queue arbiter downstream uses to pick which priorities may transmit.

The RAM runs in one of two layouts. In split mode it is two 64-entry halves used as ping-pong buffers. The running (operational) list sits in one half while the host writes the next (administrative) list into the other half. A swap request is held until the next cycle-start pulse and only then exchanges the halves, so a command is never cut short. In single mode the RAM is one 128-entry list. A gate interval longer than one command can hold is built from several back-to-back commands with the same mask. If the link stays down for longer than a parameterised time, the running schedule is dropped and all gates open.

The controller has three states. `ST_IDLE` means no schedule is active. `ST_RUN` means a command's count is running down. `ST_HOLD` means the list has ended and the last mask stays in place. The transitions are as follows:
- IDLE→RUN or IDLE→HOLD: a cycle start with a swap pending.
- RUN→RUN: the next command is loaded when a count expires.
- RUN→HOLD: the list ends.
- RUN or HOLD → RUN or HOLD: a cycle start restarts the list.
- any state → IDLE: a disable or a link-down purge.

Top module: `tsn_gate_sequencer`

## Requirements
- R1: A command is 22 bits wide. Bits [21:8] hold the duration count and bits [7:0] hold the gate mask, where bit n opens priority n.
- R2: In split mode (`split_mode`=1), a host write goes to entry `wr_addr[5:0]` of the half that is not operational, and `wr_addr[6]` is ignored. Writes never change the running schedule.
- R3: `swap_req` only marks a swap as pending. The operational half (`oper_buf`) changes, and a new schedule starts, only on the next `cycle_start`. The first activation from idle also needs a pending swap.
- R4: A command loaded at a clock edge drives its mask for exactly `count` cycles. After that, the next entry is loaded.
- R5: A command with count zero ends the list, and so does reaching the last entry of the buffer. After the list ends, the mask of the last command that ran stays applied until the next `cycle_start`.
- R6: A `cycle_start` while a schedule is active, with no swap pending, restarts the same list at entry 0.
- R7: `gate_mask` is all ones in three cases: `enable` is low (this takes effect in the same cycle, and the schedule is dropped at the next edge), no schedule is active, or the active list starts with a count of zero.
- R8: If `link_up` is sampled low on more than LINK_LIMIT consecutive edges while a schedule is active, the schedule is purged: `sched_active` falls and all gates open.
- R9: In single mode (`split_mode`=0), `wr_addr` addresses all 128 entries and one list can run through all of them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Wire-side clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| enable | input | 1 | Gating enable |
| split_mode | input | 1 | 1: two 64-entry ping-pong halves, 0: one 128-entry list |
| cycle_start | input | 1 | One-cycle pulse from the time base |
| swap_req | input | 1 | One-cycle request to activate the administrative list |
| link_up | input | 1 | Link status |
| wr_en | input | 1 | Command write strobe |
| wr_addr | input | 7 | Command write address |
| wr_data | input | 22 | Command word |
| gate_mask | output | 8 | Gate-open mask per priority |
| sched_active | output | 1 | A schedule is running or holding |
| oper_buf | output | 1 | Half currently operational in split mode |

## Verification
The assertions assume three things about the inputs. `cycle_start` and `swap_req` are single-cycle pulses. `split_mode` changes only while the sequencer is idle. The host never writes the operational half in single mode while a list runs. The bench changes the layout only after a purge has left the block idle, and in single mode it loads the list before activating it. All stimulus is driven on the falling edge, so every pulse is seen by exactly one rising edge.

// File: rtl/tgs_pkg.sv
package tgs_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_HOLD = 2'd2
    } seq_state_t;

endpackage

// File: rtl/tgs_fetch_ram.sv
module tgs_fetch_ram #(
    parameter int CMD_W = 22,
    parameter int DEPTH = 128,
    localparam int AW = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             we,
    input  logic [AW-1:0]    waddr,
    input  logic [CMD_W-1:0] wdata,
    input  logic [AW-1:0]    raddr,
    output logic [CMD_W-1:0] rdata
);

    logic [CMD_W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            mem[waddr] <= wdata;
        end
    end

    // Combinational read, so the next command is available in the cycle it is needed.
    assign rdata = mem[raddr];

endmodule

// File: rtl/tgs_link_watch.sv
module tgs_link_watch #(
    parameter int LIMIT = 125_000_000,
    localparam int CW = $clog2(LIMIT + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic armed,
    input  logic link_up,
    output logic expire
);

    logic [CW-1:0] down_cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            down_cnt <= '0;
        end else if (!armed || link_up) begin
            down_cnt <= '0;
        end else if (down_cnt != CW'(LIMIT)) begin
            down_cnt <= down_cnt + 1'b1;
        end
    end

    assign expire = armed && !link_up && (down_cnt == CW'(LIMIT));

    AST_LINK_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        down_cnt <= CW'(LIMIT)); // R8

    AST_LINK_UP_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        link_up |=> !expire); // R8

endmodule

// File: rtl/tgs_seq_fsm.sv
module tgs_seq_fsm
    import tgs_pkg::*;
#(
    parameter int CNT_W      = 14,
    parameter int MASK_W     = 8,
    parameter int HALF_DEPTH = 64,
    localparam int CMD_W = CNT_W + MASK_W,
    localparam int AW    = $clog2(2 * HALF_DEPTH),
    localparam int HAW   = AW - 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enable,
    input  logic             split_mode,
    input  logic             cycle_start,
    input  logic             swap_req,
    input  logic             purge,
    input  logic [CMD_W-1:0] rd_cmd,
    output logic [AW-1:0]    rd_addr,
    output logic [MASK_W-1:0] gate_mask,
    output logic             sched_active,
    output logic             oper_buf
);

    seq_state_t        state_q, state_d;
    logic [AW-1:0]     idx_q, idx_d;
    logic [CNT_W-1:0]  cnt_q, cnt_d;
    logic [MASK_W-1:0] mask_q, mask_d;
    logic              oper_q, oper_d;
    logic              pend_q, pend_d;

    logic [CNT_W-1:0]  cmd_cnt;
    logic [MASK_W-1:0] cmd_mask;
    logic              start_now, take_swap, rd_buf;
    logic [AW-1:0]     look_idx, last_idx;

    assign cmd_cnt  = rd_cmd[CMD_W-1:MASK_W];
    assign cmd_mask = rd_cmd[MASK_W-1:0];

    assign start_now = enable && cycle_start && !purge && (pend_q || state_q != ST_IDLE);
    assign take_swap = start_now && pend_q;
    assign last_idx  = split_mode ? AW'(HALF_DEPTH - 1) : AW'(2 * HALF_DEPTH - 1);

    // The read address is the first entry on a restart, otherwise the entry after the current one.
    always_comb begin
        look_idx = start_now ? '0 : AW'(idx_q + 1'b1);
        rd_buf   = take_swap ? ~oper_q : oper_q;
        rd_addr  = split_mode ? {rd_buf, look_idx[HAW-1:0]} : look_idx;
    end

    // Next state
    always_comb begin
        state_d = state_q;
        idx_d   = idx_q;
        cnt_d   = cnt_q;
        mask_d  = mask_q;
        oper_d  = oper_q;
        pend_d  = pend_q | swap_req;

        if (!enable || purge) begin
            state_d = ST_IDLE;
        end else if (start_now) begin
            if (take_swap) begin
                pend_d = swap_req;
                oper_d = split_mode ? ~oper_q : oper_q;
            end
            idx_d = '0;
            if (cmd_cnt == '0) begin
                state_d = ST_HOLD;
                mask_d  = '1;
            end else begin
                state_d = ST_RUN;
                mask_d  = cmd_mask;
                cnt_d   = cmd_cnt;
            end
        end else begin
            unique case (state_q)
                ST_IDLE: ;
                ST_RUN: begin
                    if (cnt_q == CNT_W'(1)) begin
                        if (idx_q == last_idx || cmd_cnt == '0) begin
                            state_d = ST_HOLD;
                        end else begin
                            idx_d  = AW'(idx_q + 1'b1);
                            cnt_d  = cmd_cnt;
                            mask_d = cmd_mask;
                        end
                    end else begin
                        cnt_d = cnt_q - 1'b1;
                    end
                end
                ST_HOLD: ;
                default: state_d = ST_IDLE;
            endcase
        end
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            idx_q   <= '0;
            cnt_q   <= '0;
            mask_q  <= '1;
            oper_q  <= 1'b0;
            pend_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            idx_q   <= idx_d;
            cnt_q   <= cnt_d;
            mask_q  <= mask_d;
            oper_q  <= oper_d;
            pend_q  <= pend_d;
        end
    end

    // Outputs
    always_comb begin
        sched_active = (state_q != ST_IDLE);
        oper_buf     = oper_q;
        gate_mask    = (!enable || state_q == ST_IDLE) ? '1 : mask_q;
    end

    AST_SWAP_AT_BOUNDARY: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(oper_q) |-> $past(cycle_start)); // R3

    AST_RUN_COUNT_LIVE: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_RUN) |-> (cnt_q != '0)); // R4

    AST_HOLD_MASK_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_HOLD && $past(state_q) == ST_HOLD && !$past(cycle_start))
        |-> $stable(mask_q)); // R5

    AST_PURGE_TO_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        purge |=> (state_q == ST_IDLE)); // R8

    AST_DISABLE_TO_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> !sched_active); // R7

endmodule

// File: rtl/tsn_gate_sequencer.sv
module tsn_gate_sequencer #(
    parameter int CNT_W      = 14,
    parameter int MASK_W     = 8,
    parameter int HALF_DEPTH = 64,
    parameter int LINK_LIMIT = 125_000_000,
    localparam int CMD_W = CNT_W + MASK_W,
    localparam int DEPTH = 2 * HALF_DEPTH,
    localparam int AW    = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enable,
    input  logic              split_mode,
    input  logic              cycle_start,
    input  logic              swap_req,
    input  logic              link_up,
    input  logic              wr_en,
    input  logic [AW-1:0]     wr_addr,
    input  logic [CMD_W-1:0]  wr_data,
    output logic [MASK_W-1:0] gate_mask,
    output logic              sched_active,
    output logic              oper_buf
);

    logic [AW-1:0]    waddr, raddr;
    logic [CMD_W-1:0] rd_cmd;
    logic             purge;

    // In split mode the host always lands in the half that is not running.
    assign waddr = split_mode ? {~oper_buf, wr_addr[AW-2:0]} : wr_addr;

    tgs_fetch_ram #(
        .CMD_W (CMD_W),
        .DEPTH (DEPTH)
    ) u_ram (
        .clk   (clk),
        .we    (wr_en),
        .waddr (waddr),
        .wdata (wr_data),
        .raddr (raddr),
        .rdata (rd_cmd)
    );

    tgs_link_watch #(
        .LIMIT (LINK_LIMIT)
    ) u_watch (
        .clk     (clk),
        .rst_n   (rst_n),
        .armed   (sched_active),
        .link_up (link_up),
        .expire  (purge)
    );

    tgs_seq_fsm #(
        .CNT_W      (CNT_W),
        .MASK_W     (MASK_W),
        .HALF_DEPTH (HALF_DEPTH)
    ) u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .enable       (enable),
        .split_mode   (split_mode),
        .cycle_start  (cycle_start),
        .swap_req     (swap_req),
        .purge        (purge),
        .rd_cmd       (rd_cmd),
        .rd_addr      (raddr),
        .gate_mask    (gate_mask),
        .sched_active (sched_active),
        .oper_buf     (oper_buf)
    );

endmodule

// File: tb/tsn_gate_sequencer_tb.sv
module tsn_gate_sequencer_tb;

    localparam int LIMIT = 20;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        enable = 1'b1;
    logic        split_mode = 1'b1;
    logic        cycle_start = 1'b0;
    logic        swap_req = 1'b0;
    logic        link_up = 1'b1;
    logic        wr_en = 1'b0;
    logic [6:0]  wr_addr = '0;
    logic [21:0] wr_data = '0;
    logic [7:0]  gate_mask;
    logic        sched_active;
    logic        oper_buf;

    int n_checks = 0;
    int n_fail   = 0;

    // 8 time units per period: 125 MHz with a 1 ns unit
    always #4 clk = ~clk;

    tsn_gate_sequencer #(.LINK_LIMIT(LIMIT)) u_dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .enable       (enable),
        .split_mode   (split_mode),
        .cycle_start  (cycle_start),
        .swap_req     (swap_req),
        .link_up      (link_up),
        .wr_en        (wr_en),
        .wr_addr      (wr_addr),
        .wr_data      (wr_data),
        .gate_mask    (gate_mask),
        .sched_active (sched_active),
        .oper_buf     (oper_buf)
    );

    // {cycle_start driven before the edge, gate_mask expected after it}
    localparam logic [8:0] VEC [12] = '{
        {1'b1, 8'h01}, {1'b0, 8'h01}, {1'b0, 8'h01}, {1'b0, 8'h06},
        {1'b0, 8'h06}, {1'b0, 8'h80}, {1'b0, 8'h80}, {1'b0, 8'h80},
        {1'b1, 8'h01}, {1'b0, 8'h01}, {1'b0, 8'h01}, {1'b0, 8'h06}
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic write_cmd(input logic [6:0] a, input logic [13:0] cnt, input logic [7:0] m);
        wr_en   = 1'b1;
        wr_addr = a;
        wr_data = {cnt, m};
        step();
        wr_en   = 1'b0;
    endtask

    task automatic pulse_swap();
        swap_req = 1'b1;
        step();
        swap_req = 1'b0;
    endtask

    task automatic pulse_start();
        cycle_start = 1'b1;
        step();
        cycle_start = 1'b0;
    endtask

    task automatic report();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        report();
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // Reset state (R7, R3)
        chk("R7 reset mask", 32'(gate_mask), 32'hFF);
        chk("R3 reset active", 32'(sched_active), 32'd0);
        chk("R3 reset oper", 32'(oper_buf), 32'd0);

        // Load a schedule into the administrative half (half 1). Field layout per R1.
        write_cmd(7'd0, 14'd3, 8'h01);
        write_cmd(7'd1, 14'd2, 8'h06);
        write_cmd(7'd2, 14'd1, 8'h80);
        write_cmd(7'd3, 14'd0, 8'hAA);

        // A cycle start without a pending swap does not activate anything (R3)
        pulse_start();
        chk("R3 no swap no start", 32'(sched_active), 32'd0);
        pulse_swap();
        chk("R3 pending only", 32'(gate_mask), 32'hFF);

        // Vector walk: countdown (R4), end marker and hold (R5), restart (R6)
        for (int k = 0; k < 12; k++) begin
            cycle_start = VEC[k][8];
            step();
            cycle_start = 1'b0;
            chk($sformatf("R4/R5/R6 vector %0d", k), 32'(gate_mask), 32'(VEC[k][7:0]));
        end
        chk("R3 oper after swap", 32'(oper_buf), 32'd1);

        // New list into half 0; wr_addr[6] set on purpose to show it is ignored (R2)
        write_cmd(7'h40, 14'd2, 8'h11);
        write_cmd(7'h41, 14'd0, 8'h00);
        pulse_swap();
        chk("R2 oper list untouched", 32'(gate_mask), 32'h80);
        step();
        chk("R3 swap deferred mask", 32'(gate_mask), 32'h80);
        chk("R3 swap deferred oper", 32'(oper_buf), 32'd1);
        pulse_start();
        chk("R3 swap at start mask", 32'(gate_mask), 32'h11);
        chk("R3 swap at start oper", 32'(oper_buf), 32'd0);
        step();
        step();
        step();
        chk("R5 last mask held", 32'(gate_mask), 32'h11);

        // Disable opens all gates at once and drops the schedule (R7)
        enable = 1'b0;
        #1;
        chk("R7 disable same cycle", 32'(gate_mask), 32'hFF);
        step();
        chk("R7 disable drops", 32'(sched_active), 32'd0);
        enable = 1'b1;
        pulse_start();
        chk("R7 stays idle", 32'(gate_mask), 32'hFF);

        // Empty list: first count zero keeps all gates open (R7), into half 1
        write_cmd(7'd0, 14'd0, 8'h55);
        pulse_swap();
        pulse_start();
        chk("R7 empty list active", 32'(sched_active), 32'd1);
        chk("R7 empty list mask", 32'(gate_mask), 32'hFF);

        // Link-down purge (R8)
        link_up = 1'b0;
        repeat (LIMIT) step();
        chk("R8 not yet purged", 32'(sched_active), 32'd1);
        link_up = 1'b1;
        step();
        link_up = 1'b0;
        repeat (LIMIT) step();
        chk("R8 count restarted", 32'(sched_active), 32'd1);
        step();
        chk("R8 purged", 32'(sched_active), 32'd0);
        chk("R8 purged mask", 32'(gate_mask), 32'hFF);
        link_up = 1'b1;

        // Single 128-entry list (R9), end of buffer ends the list (R5)
        split_mode = 1'b0;
        for (int i = 0; i < 128; i++) begin
            write_cmd(7'(i), 14'd1, 8'(i));
        end
        pulse_swap();
        pulse_start();
        chk("R9 entry 0", 32'(gate_mask), 32'h00);
        for (int j = 1; j <= 130; j++) begin
            step();
            if (j == 64 || j == 100 || j == 127) begin
                chk($sformatf("R9 entry %0d", j), 32'(gate_mask), 32'(j));
            end
        end
        chk("R5 buffer end hold", 32'(gate_mask), 32'd127);
        chk("R5 buffer end active", 32'(sched_active), 32'd1);

        report();
    end

endmodule